// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Engine

This block keeps a 16-bit stack pointer for a byte-wide data memory and turns stack requests into sequences of single-byte memory accesses. A one-byte push stores data at the current pointer and then steps the pointer down. A one-byte pop steps the pointer up and then reads. A call or interrupt entry saves a 22-bit return address as three byte writes. A return restores that address with three byte reads. Because the stack grows toward lower addresses, a save lowers the pointer and a restore raises it.

Software sees the pointer as two 8-bit halves, `sp_hi` and `sp_lo`, and can load either half through a small write port. The memory read path is combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. Writes take effect at the clock edge that ends a cycle with `mem_we` high.

The controller is a state machine with nine states. ST_IDLE accepts requests. ST_PUSH and ST_POP each run one access and then go back to ST_IDLE. A call moves through ST_CALL_LO, ST_CALL_MID and ST_CALL_HI, and then returns to ST_IDLE. A return moves through ST_RET_HI, ST_RET_MID and ST_RET_LO, and then returns to ST_IDLE. A register write taken in ST_IDLE leaves the machine in ST_IDLE.

Top module: `stk_ptr_engine`

## Requirements
- R1: After reset the pointer reads 0x21FF (`sp_hi`=0x21, `sp_lo`=0xFF), and `busy`, `done`, `mem_we` and `ovf` are all 0.
- R2: When `push_req` is taken in idle, the next cycle is a single access cycle. In that cycle `mem_we`=1, `mem_addr` equals the pointer, `mem_wdata`=`push_data` and `done`=1. After that cycle the pointer has decreased by 1.
- R3: When `pop_req` is taken in idle, the next cycle reads `mem_addr` = pointer+1 with `mem_we`=0 and `done`=1. After that cycle the pointer has increased by 1, and `pop_data` holds the byte that was read.
- R4: A `call_req` taken in idle produces three consecutive write cycles, at addresses pointer, pointer-1 and pointer-2. They carry `call_addr` bits 7:0, then bits 15:8, then bits 21:16 padded with two zero bits at the top. `done`=1 only on the third write. Afterwards the pointer has decreased by 3.
- R5: A `ret_req` taken in idle produces three consecutive read cycles, at addresses pointer+1, pointer+2 and pointer+3. The bytes read become `ret_addr` bits 21:16 (the low 6 bits of the first byte), then bits 15:8, then bits 7:0. `done`=1 only on the third read. From the next cycle on, `ret_addr` holds the full value and the pointer has increased by 3.
- R6: When several stack requests arrive in the same idle cycle, only one is served, in the priority order call, then return, then push, then pop.
- R7: In idle, `reg_wr_en` loads `reg_wr_data` into the high half of the pointer when `reg_wr_hi`=1, or into the low half when it is 0. The new value is visible from the next cycle. In that same cycle the write wins over any stack request, and the request is dropped without any memory access.
- R8: While `busy`=1, stack requests and register writes have no effect. `done` and `mem_we` are 0 whenever `busy`=0.
- R9: `ovf` is 1 exactly when the pointer is at 0x0200 or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Save a return address (call or interrupt entry) |
| call_addr | input | 22 | Return address to save |
| ret_req | input | 1 | Restore a return address |
| reg_wr_en | input | 1 | Pointer register write strobe |
| reg_wr_hi | input | 1 | 1 selects the high half, 0 selects the low half |
| reg_wr_data | input | 8 | Byte to load into the selected half |
| mem_rdata | input | 8 | Combinational read data from memory |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp_hi | output | 8 | Pointer bits 15:8 |
| sp_lo | output | 8 | Pointer bits 7:0 |
| pop_data | output | 8 | Last byte popped |
| ret_addr | output | 22 | Last restored return address |
| done | output | 1 | High on the last access cycle of an operation |
| busy | output | 1 | High while an operation is running |
| ovf | output | 1 | Pointer at or below 0x0200 |

## Verification
The bench runs an interleaved sequence of pushes, pops, calls and returns. Because the requests are mixed, the checks can tell three kinds of error apart: a wrong direction of pointer step, a wrong write-before or read-after ordering, and a wrong byte order inside the three-byte frame. The return addresses are asymmetric values such as 0x012345, and 0x3FFFFF exercises the padded top byte, so a swapped or truncated byte shows up as a wrong value. Further directed cases fire several requests at once, mix register writes with requests, send requests during a call, and step the pointer across 0x0200. These cases separate the priority rules, the ignore rules and the overflow threshold.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_CALL_LO,
        ST_CALL_MID,
        ST_CALL_HI,
        ST_RET_HI,
        ST_RET_MID,
        ST_RET_LO
    } stk_state_e;
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] RESET_SP = 16'h21FF,
    localparam int NB = ADDR_W / DATA_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_dn,
    input  logic              step_up,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] sp_plus
);
    logic [ADDR_W-1:0] sp_r;
    logic [ADDR_W-1:0] sp_ld;
    logic [ADDR_W-1:0] sp_d;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_comb begin
            if (ld_en && (ld_sel == SEL_W'(b)))
                sp_ld[b*DATA_W +: DATA_W] = ld_data;
            else
                sp_ld[b*DATA_W +: DATA_W] = sp_r[b*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        if (ld_en)        sp_d = sp_ld;
        else if (step_dn) sp_d = sp_r - ADDR_W'(1);
        else if (step_up) sp_d = sp_r + ADDR_W'(1);
        else              sp_d = sp_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_r <= RESET_SP;
        else        sp_r <= sp_d;
    end

    assign sp_q    = sp_r;
    assign sp_plus = sp_r + ADDR_W'(1);
endmodule

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RA_W   = 22,
    localparam int HI_W  = RA_W - 2*DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic [RA_W-1:0]   call_addr,
    input  logic              ret_req,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] sp_plus,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done,
    output logic              busy,
    output logic              step_dn,
    output logic              step_up,
    output logic              ld_en,
    output logic [DATA_W-1:0] pop_data,
    output logic [RA_W-1:0]   ret_addr
);
    stk_state_e        state_q, state_d;
    logic [RA_W-1:0]   save_q;
    logic [RA_W-1:0]   ret_q;
    logic [DATA_W-1:0] pop_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reg_wr_en)     state_d = ST_IDLE;
                else if (call_req) state_d = ST_CALL_LO;
                else if (ret_req)  state_d = ST_RET_HI;
                else if (push_req) state_d = ST_PUSH;
                else if (pop_req)  state_d = ST_POP;
            end
            ST_PUSH, ST_POP:  state_d = ST_IDLE;
            ST_CALL_LO:       state_d = ST_CALL_MID;
            ST_CALL_MID:      state_d = ST_CALL_HI;
            ST_CALL_HI:       state_d = ST_IDLE;
            ST_RET_HI:        state_d = ST_RET_MID;
            ST_RET_MID:       state_d = ST_RET_LO;
            ST_RET_LO:        state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q <= '0;
            ret_q  <= '0;
            pop_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!reg_wr_en) begin
                        if (call_req)      save_q <= call_addr;
                        else if (push_req) save_q <= RA_W'(push_data);
                    end
                end
                ST_POP:     pop_q <= mem_rdata;
                ST_RET_HI:  ret_q[RA_W-1:2*DATA_W]   <= mem_rdata[HI_W-1:0];
                ST_RET_MID: ret_q[2*DATA_W-1:DATA_W] <= mem_rdata;
                ST_RET_LO:  ret_q[DATA_W-1:0]        <= mem_rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr  = sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        done      = 1'b0;
        step_dn   = 1'b0;
        step_up   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH: begin
                mem_we = 1'b1; mem_wdata = save_q[DATA_W-1:0];
                step_dn = 1'b1; done = 1'b1;
            end
            ST_POP: begin
                mem_addr = sp_plus; step_up = 1'b1; done = 1'b1;
            end
            ST_CALL_LO: begin
                mem_we = 1'b1; mem_wdata = save_q[DATA_W-1:0]; step_dn = 1'b1;
            end
            ST_CALL_MID: begin
                mem_we = 1'b1; mem_wdata = save_q[2*DATA_W-1:DATA_W]; step_dn = 1'b1;
            end
            ST_CALL_HI: begin
                mem_we = 1'b1; mem_wdata = DATA_W'(save_q[RA_W-1:2*DATA_W]);
                step_dn = 1'b1; done = 1'b1;
            end
            ST_RET_HI, ST_RET_MID: begin
                mem_addr = sp_plus; step_up = 1'b1;
            end
            ST_RET_LO: begin
                mem_addr = sp_plus; step_up = 1'b1; done = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign ld_en    = (state_q == ST_IDLE) && reg_wr_en;
    assign pop_data = pop_q;
    assign ret_addr = ret_q;
endmodule

// File: rtl/stk_ptr_engine.sv
module stk_ptr_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RA_W   = 22,
    parameter logic [ADDR_W-1:0] RESET_SP = 16'h21FF,
    parameter logic [ADDR_W-1:0] FLOOR    = 16'h0200,
    localparam int NB    = ADDR_W / DATA_W,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic [RA_W-1:0]   call_addr,
    input  logic              ret_req,
    input  logic              reg_wr_en,
    input  logic              reg_wr_hi,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] sp_hi,
    output logic [DATA_W-1:0] sp_lo,
    output logic [DATA_W-1:0] pop_data,
    output logic [RA_W-1:0]   ret_addr,
    output logic              done,
    output logic              busy,
    output logic              ovf
);
    logic [ADDR_W-1:0] sp;
    logic [ADDR_W-1:0] sp_plus;
    logic              step_dn;
    logic              step_up;
    logic              ld_en;

    stk_ptr_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_SP(RESET_SP)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .step_dn(step_dn), .step_up(step_up),
        .ld_en(ld_en), .ld_sel(SEL_W'(reg_wr_hi)), .ld_data(reg_wr_data),
        .sp_q(sp), .sp_plus(sp_plus)
    );

    stk_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RA_W(RA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .call_req(call_req), .call_addr(call_addr), .ret_req(ret_req),
        .reg_wr_en(reg_wr_en), .sp(sp), .sp_plus(sp_plus),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .busy(busy),
        .step_dn(step_dn), .step_up(step_up), .ld_en(ld_en),
        .pop_data(pop_data), .ret_addr(ret_addr)
    );

    assign sp_hi = sp[ADDR_W-1:ADDR_W-DATA_W];
    assign sp_lo = sp[DATA_W-1:0];
    assign ovf   = (sp <= FLOOR);
endmodule

// File: rtl/stk_ptr_engine_chk.sv
module stk_ptr_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] FLOOR = 16'h0200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] sp_hi,
    input logic [DATA_W-1:0] sp_lo,
    input logic              ovf
);
    logic [ADDR_W-1:0] sp_v;
    assign sp_v = ADDR_W'({sp_hi, sp_lo});

    // R2 R4: every write lands on the current pointer
    a_r2_write_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp_v));
    // R2 R4: every write lowers the pointer by one
    a_r4_write_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_v == $past(sp_v) - ADDR_W'(1)));
    // R3 R5: reads go one above the pointer
    a_r3_read_above_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |-> (mem_addr == sp_v + ADDR_W'(1)));
    // R5: every read raises the pointer by one
    a_r5_read_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> (sp_v == $past(sp_v) + ADDR_W'(1)));
    // R8: no access or done while idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !done));
    // R8: done ends the operation
    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9: overflow flag tracks the threshold
    a_r9_ovf_level: assert property (@(posedge clk) disable iff (!rst_n)
        ovf == (sp_v <= FLOOR));
endmodule

bind stk_ptr_engine stk_ptr_engine_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLOOR(FLOOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_addr(mem_addr), .sp_hi(sp_hi), .sp_lo(sp_lo), .ovf(ovf)
);

// File: tb/stk_ptr_engine_bench.sv
`timescale 1ns/1ps
module stk_ptr_engine_bench;
    localparam logic [1:0] OP_PUSH = 2'd0;
    localparam logic [1:0] OP_POP  = 2'd1;
    localparam logic [1:0] OP_CALL = 2'd2;
    localparam logic [1:0] OP_RET  = 2'd3;
    localparam int NV = 10;
    // {op, data, expected result}
    localparam logic [49:0] VEC [NV] = '{
        {OP_PUSH, 24'h0000A5, 24'h0},
        {OP_CALL, 24'h012345, 24'h0},
        {OP_RET,  24'h0,      24'h012345},
        {OP_POP,  24'h0,      24'h0000A5},
        {OP_CALL, 24'h3FFFFF, 24'h0},
        {OP_PUSH, 24'h00005A, 24'h0},
        {OP_POP,  24'h0,      24'h00005A},
        {OP_RET,  24'h0,      24'h3FFFFF},
        {OP_PUSH, 24'h000000, 24'h0},
        {OP_POP,  24'h0,      24'h000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_req = 0, pop_req = 0, call_req = 0, ret_req = 0;
    logic reg_wr_en = 0, reg_wr_hi = 0;
    logic [7:0] push_data = 0, reg_wr_data = 0;
    logic [21:0] call_addr = 0;
    logic [7:0] mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, sp_hi, sp_lo, pop_data;
    logic mem_we, done, busy, ovf;
    logic [21:0] ret_addr;
    logic [7:0] mem [1024];

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] sp_m;

    always #4 clk = ~clk;

    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[9:0]];

    stk_ptr_engine u_stk_ptr_engine (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .call_req(call_req), .call_addr(call_addr),
        .ret_req(ret_req), .reg_wr_en(reg_wr_en), .reg_wr_hi(reg_wr_hi),
        .reg_wr_data(reg_wr_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .sp_hi(sp_hi), .sp_lo(sp_lo),
        .pop_data(pop_data), .ret_addr(ret_addr), .done(done), .busy(busy),
        .ovf(ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sp_now();
        return {sp_hi, sp_lo};
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [23:0] data, input logic [23:0] exp);
        int nb;
        nb = (op == OP_PUSH || op == OP_POP) ? 1 : 3;
        @(negedge clk);
        push_req = (op == OP_PUSH); pop_req = (op == OP_POP);
        call_req = (op == OP_CALL); ret_req = (op == OP_RET);
        push_data = data[7:0]; call_addr = data[21:0];
        @(negedge clk);
        push_req = 0; pop_req = 0; call_req = 0; ret_req = 0;
        for (int k = 0; k < nb; k++) begin
            if (op == OP_PUSH || op == OP_CALL) begin
                chk("R2/R4 write address", mem_addr, sp_m - 16'(k));
                chk("R2/R4 write enable", mem_we, 1);
                chk("R2/R4 write byte", mem_wdata, (op == OP_PUSH) ? data[7:0] : data[8*k +: 8]);
            end else begin
                chk("R3/R5 read address", mem_addr, sp_m + 16'(k + 1));
                chk("R3/R5 no write", mem_we, 0);
            end
            chk("R4/R5 done timing", done, (k == nb - 1));
            @(negedge clk);
        end
        case (op)
            OP_PUSH: sp_m = sp_m - 16'd1;
            OP_POP:  sp_m = sp_m + 16'd1;
            OP_CALL: sp_m = sp_m - 16'd3;
            default: sp_m = sp_m + 16'd3;
        endcase
        chk("R2-R5 pointer after op", sp_now(), sp_m);
        chk("R8 idle after op", busy, 0);
        if (op == OP_POP) chk("R3 pop data", pop_data, exp[7:0]);
        if (op == OP_RET) chk("R5 return address", ret_addr, exp[21:0]);
    endtask

    task automatic wr_reg(input logic hi, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_wr_hi = hi; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset pointer", sp_now(), 16'h21FF);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset write", mem_we, 0);
        chk("R1 reset ovf", ovf, 0);
        sp_m = 16'h21FF;

        for (int v = 0; v < NV; v++)
            run_op(VEC[v][49:48], VEC[v][47:24], VEC[v][23:0]);

        // R6: all four requests together, call wins
        @(negedge clk);
        push_req = 1; pop_req = 1; call_req = 1; ret_req = 1;
        push_data = 8'hEE; call_addr = 22'h0A0B0C;
        @(negedge clk);
        push_req = 0; pop_req = 0; call_req = 0; ret_req = 0;
        chk("R6 call wins first byte", mem_wdata, 8'h0C);
        repeat (3) @(negedge clk);
        sp_m = sp_m - 16'd3;
        chk("R6 call wins pointer", sp_now(), sp_m);
        // R6: return beats push and pop
        @(negedge clk);
        push_req = 1; pop_req = 1; ret_req = 1;
        @(negedge clk);
        push_req = 0; pop_req = 0; ret_req = 0;
        chk("R6 return wins no write", mem_we, 0);
        repeat (3) @(negedge clk);
        sp_m = sp_m + 16'd3;
        chk("R6 return wins value", ret_addr, 22'h0A0B0C);
        chk("R6 return wins pointer", sp_now(), sp_m);

        // R7: register loads
        wr_reg(1'b1, 8'h12);
        chk("R7 high load", sp_now(), {8'h12, sp_m[7:0]});
        wr_reg(1'b0, 8'h34);
        chk("R7 low load", sp_now(), 16'h1234);
        sp_m = 16'h1234;
        // R7: write beats push in the same cycle
        @(negedge clk);
        reg_wr_en = 1; reg_wr_hi = 0; reg_wr_data = 8'h40; push_req = 1; push_data = 8'h77;
        @(negedge clk);
        reg_wr_en = 0; push_req = 0;
        chk("R7 write wins no access", mem_we, 0);
        chk("R7 write wins busy", busy, 0);
        chk("R7 write wins pointer", sp_now(), 16'h1240);
        sp_m = 16'h1240;

        // R8: requests and writes during a call are ignored
        @(negedge clk);
        call_req = 1; call_addr = 22'h111111;
        @(negedge clk);
        call_req = 0;
        reg_wr_en = 1; reg_wr_hi = 1; reg_wr_data = 8'hFF; pop_req = 1;
        @(negedge clk);
        @(negedge clk);
        reg_wr_en = 0; pop_req = 0;
        chk("R8 busy through call", done, 1);
        @(negedge clk);
        sp_m = sp_m - 16'd3;
        chk("R8 ignored while busy pointer", sp_now(), sp_m);
        chk("R8 ignored while busy idle", busy, 0);

        // R9: overflow threshold
        wr_reg(1'b1, 8'h02);
        wr_reg(1'b0, 8'h01);
        sp_m = 16'h0201;
        chk("R9 ovf clear at 0x0201", ovf, 0);
        run_op(OP_PUSH, 24'h000099, 24'h0);
        chk("R9 ovf set at 0x0200", ovf, 1);
        run_op(OP_POP, 24'h0, 24'h000099);
        chk("R9 ovf clear after pop", ovf, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule